// File: doc/BRIEF.md
# Incrementing AHB Burst Master with Stall Insertion

This block is an AHB-Lite master engine. It runs one incrementing read or write burst for each command it receives. A command carries a start address, a beat count and a direction. On the local side, a back-end supplies write data and takes read data. The back-end also holds a single `beat_ok` level that says whether it can commit to the next beat.

Inside a burst, `beat_ok` low makes the engine put BUSY on the bus. The address and control lines keep showing the next beat while BUSY is driven. The beat already in its data phase still completes as soon as the slave raises HREADY, so read data is captured and write data is held on that edge whatever HTRANS shows at the time. Outside a burst, the engine never issues BUSY. Before the first beat of a burst, `beat_ok` low keeps the bus at IDLE.

A burst ends in one of two ways. Either every beat has completed, or the slave answers a beat with ERROR. In both cases the engine returns the bus to IDLE and pulses `done`, and `done_err` tells the two cases apart.

Top module: `ahb_burst_master`

## Requirements
- R1: After reset, HTRANS is IDLE (2'b00), `cmd_ready` is 1, and `done`, `be_rvalid` and `be_wtake` are 0.
- R2: The first beat of a burst is NONSEQ (2'b10) and every later beat is SEQ (2'b11). Beat k has address start + 4·k for the default 32-bit data width. HSIZE is 3'b010 and HBURST is INCR (3'b001).
- R3: When `beat_ok` is low inside a burst, the next address phase is BUSY (2'b01) with HADDR equal to the address of the next beat. A BUSY phase does not advance the address. With `beat_ok` held high, no BUSY appears.
- R4: BUSY never appears before the first beat of a burst is accepted. While `beat_ok` is low after a command is taken, HTRANS stays IDLE.
- R5: While HREADY is low and HRESP is OKAY, HTRANS, HADDR and HWRITE keep their values for any non-IDLE transfer.
- R6: Read data is captured on the edge where a NONSEQ/SEQ read data phase completes with HREADY high and OKAY. It appears one cycle later on `be_rdata` with a one-cycle `be_rvalid` pulse, exactly once per beat and in address order. Data phases that follow BUSY or IDLE produce no pulse.
- R7: `be_wtake` is high in the cycle in which a write beat's address phase is accepted. In that cycle `be_wdata` is registered onto HWDATA, and it is held through the data phase, including its wait states.
- R8: When the final data phase completes with OKAY, `done` pulses for one cycle with `done_err` at 0, and `cmd_ready` is 1 in that cycle.
- R9: In the first cycle of an ERROR response (HRESP 1, HREADY 0), the engine changes HTRANS to IDLE. No further beat is issued. The errored beat gives no `be_rvalid`. `done` then pulses with `done_err` at 1.
- R10: `cmd_len` holds the number of beats minus one, so 0 requests a single beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, command taken when valid |
| cmd_addr | input | AW | Start byte address |
| cmd_len | input | LW | Beats minus one |
| cmd_write | input | 1 | 1 for a write burst, 0 for a read burst |
| beat_ok | input | 1 | Back-end can commit to the next beat |
| be_wdata | input | DW | Write data for the beat in its address phase |
| be_wtake | output | 1 | Write data consumed this cycle |
| be_rdata | output | DW | Captured read data |
| be_rvalid | output | 1 | Read data strobe, one per completed read beat |
| done | output | 1 | Burst finished pulse |
| done_err | output | 1 | Burst ended on an ERROR response (valid with done) |
| haddr | output | AW | Bus address |
| htrans | output | 2 | Transfer type |
| hwrite | output | 1 | Transfer direction |
| hsize | output | 3 | Transfer size |
| hburst | output | 3 | Burst type, always INCR |
| hwdata | output | DW | Bus write data |
| hrdata | input | DW | Bus read data |
| hready | input | 1 | Transfer done / bus ready |
| hresp | input | 1 | Response, 1 = ERROR |

## Verification
The hardest case to reach is a BUSY address phase that sits on the bus while the previous beat's data phase is stretched by wait states. The engine must not let that beat's data depend on the BUSY, and must not take anything from the undefined data phase that follows. The bench's slave model returns marker data whenever a data phase is not valid, including during wait cycles. Per-cycle random `beat_ok` and per-beat random wait counts then bring BUSY and wait states into overlap many times in each burst. An ERROR injected at a chosen beat index, while BUSY or SEQ is pending, exercises the cancel path.

// File: rtl/ahbm_pkg.sv
package ahbm_pkg;
  typedef enum logic [1:0] {
    HT_IDLE   = 2'b00,
    HT_BUSY   = 2'b01,
    HT_NONSEQ = 2'b10,
    HT_SEQ    = 2'b11
  } htrans_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_BURST,
    ST_DRAIN
  } eng_st_t;

  localparam logic [2:0] HBURST_INCR = 3'b001;
endpackage

// File: rtl/ahbm_addr_ctrl.sv
module ahbm_addr_ctrl
  import ahbm_pkg::*;
#(
  parameter int AW   = 32,
  parameter int LW   = 8,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  input  logic          cmd_write,
  input  logic          beat_ok,
  input  logic          hready,
  input  logic          hresp,
  input  logic          dp_valid,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic          hwrite,
  output logic          done,
  output logic          done_err
);
  localparam int CW = LW + 1;

  eng_st_t       state_q, state_n;
  htrans_t       htrans_q, htrans_n;
  logic [AW-1:0] haddr_q, haddr_n;
  logic          hwrite_q, hwrite_n;
  logic [CW-1:0] rem_q, rem_n;
  logic          done_q, done_n;
  logic          err_q, err_n;
  logic          addr_acc;
  htrans_t       cont_tr;

  assign addr_acc = hready && htrans_q[1];
  assign cont_tr  = beat_ok ? HT_SEQ : HT_BUSY;

  always_comb begin
    state_n  = state_q;
    htrans_n = htrans_q;
    haddr_n  = haddr_q;
    hwrite_n = hwrite_q;
    rem_n    = rem_q;
    done_n   = 1'b0;
    err_n    = err_q;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          state_n  = ST_WAIT;
          rem_n    = {1'b0, cmd_len} + CW'(1);
          haddr_n  = cmd_addr;
          hwrite_n = cmd_write;
        end
      end
      ST_WAIT: begin
        if (hready && beat_ok) begin
          htrans_n = HT_NONSEQ;
          state_n  = ST_BURST;
        end
      end
      ST_BURST: begin
        if (hresp && !hready) begin
          htrans_n = HT_IDLE;
          state_n  = ST_DRAIN;
        end else if (hready) begin
          if (addr_acc) begin
            rem_n = rem_q - CW'(1);
            if (rem_q == CW'(1)) begin
              htrans_n = HT_IDLE;
              state_n  = ST_DRAIN;
            end else begin
              haddr_n  = haddr_q + AW'(STEP);
              htrans_n = cont_tr;
            end
          end else begin
            htrans_n = cont_tr;
          end
        end
      end
      ST_DRAIN: begin
        if (hready) begin
          done_n  = 1'b1;
          err_n   = hresp && dp_valid;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      htrans_q <= HT_IDLE;
      haddr_q  <= '0;
      hwrite_q <= 1'b0;
      rem_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      state_q  <= state_n;
      htrans_q <= htrans_n;
      haddr_q  <= haddr_n;
      hwrite_q <= hwrite_n;
      rem_q    <= rem_n;
      done_q   <= done_n;
      err_q    <= err_n;
    end
  end

  assign cmd_ready = (state_q == ST_IDLE);
  assign haddr     = haddr_q;
  assign htrans    = htrans_q;
  assign hwrite    = hwrite_q;
  assign done      = done_q;
  assign done_err  = err_q;

  // R5
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!hready && !hresp && htrans_q != HT_IDLE) |=>
      (htrans_q == $past(htrans_q) && haddr_q == $past(haddr_q) && hwrite_q == $past(hwrite_q)));

  // R4
  busy_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (htrans_q == HT_BUSY) |-> ($past(htrans_q) != HT_IDLE));

  // R3
  busy_keep_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hready && !hresp && htrans_q == HT_BUSY) |=> (haddr_q == $past(haddr_q)));

  // R2
  seq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_acc && !hresp && state_q == ST_BURST && rem_q > CW'(1)) |=>
      (haddr_q == $past(haddr_q) + AW'(STEP) && htrans_q != HT_NONSEQ && htrans_q != HT_IDLE));

  // R9
  err_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_BURST && hresp && !hready) |=> (htrans_q == HT_IDLE));
endmodule

// File: rtl/ahbm_data_pipe.sv
module ahbm_data_pipe #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    htrans,
  input  logic          hwrite,
  input  logic          hready,
  input  logic          hresp,
  input  logic [DW-1:0] hrdata,
  input  logic [DW-1:0] be_wdata,
  output logic          dp_valid,
  output logic [DW-1:0] hwdata,
  output logic          be_wtake,
  output logic [DW-1:0] be_rdata,
  output logic          be_rvalid
);
  logic          dpv_q, dpv_n;
  logic          dpw_q, dpw_n;
  logic [DW-1:0] wd_q, wd_n;
  logic [DW-1:0] rd_q, rd_n;
  logic          rv_q, rv_n;
  logic          wtake;
  logic          rd_done;

  assign wtake   = hready && htrans[1] && hwrite;
  assign rd_done = hready && dpv_q && !dpw_q && !hresp;

  always_comb begin
    dpv_n = dpv_q;
    dpw_n = dpw_q;
    wd_n  = wd_q;
    rd_n  = rd_q;
    rv_n  = rd_done;
    if (hready) begin
      dpv_n = htrans[1];
      dpw_n = hwrite;
    end
    if (wtake) wd_n = be_wdata;
    if (rd_done) rd_n = hrdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dpv_q <= 1'b0;
      dpw_q <= 1'b0;
      wd_q  <= '0;
      rd_q  <= '0;
      rv_q  <= 1'b0;
    end else begin
      dpv_q <= dpv_n;
      dpw_q <= dpw_n;
      wd_q  <= wd_n;
      rd_q  <= rd_n;
      rv_q  <= rv_n;
    end
  end

  assign dp_valid  = dpv_q;
  assign hwdata    = wd_q;
  assign be_wtake  = wtake;
  assign be_rdata  = rd_q;
  assign be_rvalid = rv_q;

  // R7
  wdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dpv_q && dpw_q && !hready) |=> (wd_q == $past(wd_q)));

  // R6
  rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rv_q |-> $past(hready && dpv_q && !dpw_q && !hresp));
endmodule

// File: rtl/ahb_burst_master.sv
module ahb_burst_master
  import ahbm_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [AW-1:0] cmd_addr,
  input  logic [LW-1:0] cmd_len,
  input  logic          cmd_write,
  input  logic          beat_ok,
  input  logic [DW-1:0] be_wdata,
  output logic          be_wtake,
  output logic [DW-1:0] be_rdata,
  output logic          be_rvalid,
  output logic          done,
  output logic          done_err,
  output logic [AW-1:0] haddr,
  output logic [1:0]    htrans,
  output logic          hwrite,
  output logic [2:0]    hsize,
  output logic [2:0]    hburst,
  output logic [DW-1:0] hwdata,
  input  logic [DW-1:0] hrdata,
  input  logic          hready,
  input  logic          hresp
);
  localparam int STEP      = DW / 8;
  localparam int BYTES_LOG = $clog2(STEP);

  logic dp_valid;

  ahbm_addr_ctrl #(.AW(AW), .LW(LW), .STEP(STEP)) u_addr (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_len(cmd_len), .cmd_write(cmd_write), .beat_ok(beat_ok),
    .hready(hready), .hresp(hresp), .dp_valid(dp_valid),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .done(done), .done_err(done_err)
  );

  ahbm_data_pipe #(.DW(DW)) u_data (
    .clk(clk), .rst_n(rst_n),
    .htrans(htrans), .hwrite(hwrite), .hready(hready), .hresp(hresp),
    .hrdata(hrdata), .be_wdata(be_wdata), .dp_valid(dp_valid),
    .hwdata(hwdata), .be_wtake(be_wtake), .be_rdata(be_rdata), .be_rvalid(be_rvalid)
  );

  assign hsize  = 3'(BYTES_LOG);
  assign hburst = HBURST_INCR;

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd_ready && !dp_valid));
endmodule

// File: tb/test_ahb_burst_master.sv
module test_ahb_burst_master;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [31:0] cmd_addr;
  logic [7:0]  cmd_len;
  logic        cmd_write;
  logic        beat_ok;
  logic [31:0] be_wdata;
  logic        be_wtake;
  logic [31:0] be_rdata;
  logic        be_rvalid;
  logic        done, done_err;
  logic [31:0] haddr;
  logic [1:0]  htrans;
  logic        hwrite;
  logic [2:0]  hsize, hburst;
  logic [31:0] hwdata, hrdata;
  logic        hready, hresp;

  int tests = 0;
  int fails = 0;
  int busy_pct = 0, wmax = 0, err_beat = -1, hold_cfg = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  ahb_burst_master i_ahb_burst_master (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_write(cmd_write), .beat_ok(beat_ok),
    .be_wdata(be_wdata), .be_wtake(be_wtake), .be_rdata(be_rdata), .be_rvalid(be_rvalid),
    .done(done), .done_err(done_err), .haddr(haddr), .htrans(htrans), .hwrite(hwrite),
    .hsize(hsize), .hburst(hburst), .hwdata(hwdata), .hrdata(hrdata),
    .hready(hready), .hresp(hresp)
  );

  // slave model
  logic [31:0] mem [64];
  logic        sl_valid, sl_write;
  logic [5:0]  sl_idx;
  int          wait_cnt, err_ph, sl_cnt;

  assign hready = (err_ph == 2) ? 1'b0 : (err_ph == 1) ? 1'b1 : (wait_cnt == 0);
  assign hresp  = (err_ph != 0);
  assign hrdata = (sl_valid && !sl_write && err_ph == 0 && wait_cnt == 0) ? mem[sl_idx]
                                                                          : (32'hDEAD0000 | 32'(cyc[15:0]));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mem[i] <= 32'h10000000 + 32'(i) * 32'h0101;
      sl_valid <= 1'b0; sl_write <= 1'b0; sl_idx <= '0;
      wait_cnt <= 0; err_ph <= 0; sl_cnt <= 0;
    end else begin
      if (err_ph == 2) err_ph <= 1;
      else if (err_ph == 1) err_ph <= 0;
      if (cmd_valid && cmd_ready) sl_cnt <= 0;
      if (hready) begin
        if (sl_valid && sl_write && !hresp) mem[sl_idx] <= hwdata;
        sl_valid <= htrans[1];
        sl_idx   <= haddr[7:2];
        sl_write <= hwrite;
        if (htrans[1]) begin
          if (sl_cnt == err_beat) begin
            err_ph   <= 2;
            wait_cnt <= 0;
          end else begin
            wait_cnt <= int'($urandom_range(wmax, 0));
          end
          sl_cnt <= sl_cnt + 1;
        end
      end else if (wait_cnt > 0) begin
        wait_cnt <= wait_cnt - 1;
      end
    end
  end

  // monitor
  int          nacc, nbusy, busy_bad, addr_bad, hold_bad, nrd, rd_bad, nwr, ndone, cyc_since;
  logic        done_err_seen;
  logic [31:0] start_q;
  logic        h_chk;
  logic [1:0]  h_tr;
  logic [31:0] h_addr;

  assign be_wdata = 32'hC0DE0000 ^ (start_q << 12) ^ 32'(nwr);

  always @(posedge clk) begin
    if (!rst_n) begin
      nacc <= 0; nbusy <= 0; busy_bad <= 0; addr_bad <= 0; hold_bad <= 0;
      nrd <= 0; rd_bad <= 0; nwr <= 0; ndone <= 0; cyc_since <= 1000;
      done_err_seen <= 1'b0; start_q <= '0; h_chk <= 1'b0; h_tr <= '0; h_addr <= '0;
    end else if (cmd_valid && cmd_ready) begin
      nacc <= 0; nbusy <= 0; busy_bad <= 0; addr_bad <= 0; hold_bad <= 0;
      nrd <= 0; rd_bad <= 0; nwr <= 0; ndone <= 0; cyc_since <= 0;
      done_err_seen <= 1'b0; start_q <= cmd_addr; h_chk <= 1'b0;
    end else begin
      cyc_since <= cyc_since + 1;
      if (h_chk && (htrans != h_tr || haddr != h_addr)) hold_bad <= hold_bad + 1;
      h_chk  <= !hready && !hresp && htrans != 2'b00;
      h_tr   <= htrans;
      h_addr <= haddr;
      if (hready && htrans[1]) begin
        if (haddr != start_q + 32'(nacc) * 4 || htrans != ((nacc == 0) ? 2'b10 : 2'b11) ||
            hsize != 3'b010 || hburst != 3'b001)
          addr_bad <= addr_bad + 1;
        nacc <= nacc + 1;
      end
      if (htrans == 2'b01) begin
        nbusy <= nbusy + 1;
        if (nacc == 0) busy_bad <= busy_bad + 1;
        if (haddr != start_q + 32'(nacc) * 4) addr_bad <= addr_bad + 1;
      end
      if (be_rvalid) begin
        if (be_rdata != mem[6'(start_q[7:2] + 6'(nrd))]) rd_bad <= rd_bad + 1;
        nrd <= nrd + 1;
      end
      if (be_wtake) nwr <= nwr + 1;
      if (done) begin
        ndone <= ndone + 1;
        done_err_seen <= done_err;
      end
    end
  end

  always @(negedge clk)
    beat_ok <= (cyc_since < hold_cfg) ? 1'b0 : (int'($urandom_range(99, 0)) >= busy_pct);

  // watchdog
  always @(posedge clk)
    if (cyc > 150000) begin
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests + 1, fails + 1);
      $finish;
    end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] a, input int beats, input bit wr,
                     input int bp, input int wm, input int eb, input int hold);
    busy_pct = bp; wmax = wm; err_beat = eb; hold_cfg = hold;
    @(negedge clk);
    cmd_addr = a; cmd_len = 8'(beats - 1); cmd_write = wr; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    begin
      bit idle_ok = 1'b1;
      for (int i = 0; i < hold - 1; i++) begin
        if (htrans != 2'b00) idle_ok = 1'b0;
        @(negedge clk);
      end
      if (hold > 0) check(idle_ok, "R4", "IDLE while beat_ok low before first beat", idle_ok, 1);
    end
    for (int i = 0; i < 3000 && ndone == 0; i++) @(negedge clk);
    check(ndone == 1, "R8", "done pulse count", ndone, 1);
    check(cmd_ready == 1'b1 && done == 1'b0, "R8", "idle after done", cmd_ready, 1);
  endtask

  task automatic common(input logic [31:0] a, input int beats, input bit wr, input int eb);
    int exp_acc = (eb < 0) ? beats : eb + 1;
    int exp_dat = (eb < 0) ? beats : eb;
    check(nacc == exp_acc, "R10", "beats issued", nacc, exp_acc);
    check(addr_bad == 0, "R2", "address/type/size errors", addr_bad, 0);
    check(hold_bad == 0, "R5", "changes during wait states", hold_bad, 0);
    check(busy_bad == 0, "R4", "BUSY before first beat", busy_bad, 0);
    if (eb >= 0) check(done_err_seen == 1'b1, "R9", "done_err", done_err_seen, 1);
    else         check(done_err_seen == 1'b0, "R8", "done_err", done_err_seen, 0);
    if (!wr) begin
      check(nrd == exp_dat, "R6", "read strobes", nrd, exp_dat);
      check(rd_bad == 0, "R6", "read data mismatches", rd_bad, 0);
      check(nwr == 0, "R7", "write takes on read", nwr, 0);
    end else begin
      int bad = 0;
      check(nwr == exp_acc, "R7", "write takes", nwr, exp_acc);
      check(nrd == 0, "R6", "read strobes on write", nrd, 0);
      for (int k = 0; k < exp_dat; k++)
        if (mem[6'(a[7:2] + 6'(k))] != (32'hC0DE0000 ^ (a << 12) ^ 32'(k))) bad++;
      check(bad == 0, "R7", "written words wrong", bad, 0);
    end
  endtask

  task automatic t_reset;
    check(htrans == 2'b00, "R1", "htrans after reset", htrans, 0);
    check(cmd_ready == 1'b1, "R1", "cmd_ready after reset", cmd_ready, 1);
    check(done == 1'b0 && be_rvalid == 1'b0 && be_wtake == 1'b0, "R1", "strobes after reset",
          {done, be_rvalid, be_wtake}, 0);
  endtask

  task automatic t_plain_read;
    run(32'h20, 4, 1'b0, 0, 0, -1, 0);
    common(32'h20, 4, 1'b0, -1);
    check(nbusy == 0, "R3", "BUSY with beat_ok high", nbusy, 0);
  endtask

  task automatic t_write_waits;
    run(32'h40, 8, 1'b1, 0, 3, -1, 0);
    common(32'h40, 8, 1'b1, -1);
  endtask

  task automatic t_read_busy;
    run(32'h00, 16, 1'b0, 50, 2, -1, 0);
    common(32'h00, 16, 1'b0, -1);
    check(nbusy > 0, "R3", "BUSY phases seen", nbusy, 1);
  endtask

  task automatic t_write_busy_hold;
    run(32'h80, 12, 1'b1, 40, 2, -1, 6);
    common(32'h80, 12, 1'b1, -1);
    check(nbusy > 0, "R3", "BUSY phases seen on write", nbusy, 1);
  endtask

  task automatic t_single;
    run(32'hC0, 1, 1'b0, 0, 2, -1, 0);
    common(32'hC0, 1, 1'b0, -1);
  endtask

  task automatic t_read_err;
    run(32'h10, 8, 1'b0, 30, 1, 2, 0);
    common(32'h10, 8, 1'b0, 2);
  endtask

  task automatic t_write_err;
    run(32'h60, 6, 1'b1, 0, 0, 3, 0);
    common(32'h60, 6, 1'b1, 3);
  endtask

  task automatic t_readback;
    run(32'h40, 8, 1'b0, 60, 3, -1, 0);
    common(32'h40, 8, 1'b0, -1);
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_addr = '0; cmd_len = '0; cmd_write = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_plain_read;
    t_write_waits;
    t_read_busy;
    t_write_busy_hold;
    t_single;
    t_read_err;
    t_write_err;
    t_readback;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule